// File: doc/BRIEF.md
# Ascending Virtual Channel Selector

This block picks the output virtual channel for a packet header at one output port of a network-on-chip router. Its policy keeps the higher-numbered channels idle under light traffic, so their buffers can stay power-gated. A header starts on the lowest channel when it enters the network. It keeps its present channel while that channel is free. When that channel is occupied downstream, the header moves up to the next free channel. It never moves to a lower channel.

The selector accepts a header with a one-cycle strobe and holds it in a pending state. While pending, it re-evaluates the downstream occupancy vector on every cycle. When the channel it would grant is still asleep, it raises a one-hot wake request for that channel. It issues the grant only after that channel reports awake. Light load therefore touches only channel 0. Sustained conflicts progressively wake the upper channels. The channel count is a parameter from 1 to 4.

Top module: `vc_selector`

## Requirements
- R1: After reset, `grant_valid` is low and `wake_req` is all zeros.
- R2: When the selector is idle, a header strobed on `hdr_valid` at clock edge k is registered at that edge. The earliest grant is visible after edge k+1. `grant_valid` is a single-cycle pulse.
- R3: When `inject` is high with the strobe, the starting channel is 0, whatever `hdr_vc` holds.
- R4: A `hdr_vc` value above NUM_VC-1 is treated as starting channel NUM_VC-1.
- R5: `vc_busy[i]` = 1 means channel i is occupied and 0 means it is free. If the starting channel is free, it is the channel granted.
- R6: If the starting channel is occupied, the lowest free channel strictly above it is granted. A channel below the starting channel is never granted.
- R7: If no channel at or above the start is free, no grant is issued. The selector retries on every cycle with the current `vc_busy`, and grants on the edge after a suitable channel becomes free.
- R8: `vc_awake[i]` = 0 means channel i is asleep. If the chosen channel is asleep, `wake_req` holds a one-hot bit i for it and no grant is issued. The grant follows on the edge after `vc_awake[i]` is seen high.
- R9: A `hdr_valid` strobe that arrives while a header is pending is ignored. The pending header's starting channel is unchanged.
- R10: A grant names only a channel that was free and awake in the cycle it was decided. `wake_req` has at most one bit set, and is zero whenever `grant_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | One-cycle strobe offering a header |
| hdr_vc | input | VCW | Header's current channel number |
| inject | input | 1 | Header comes from the local injection port |
| vc_busy | input | NUM_VC | Per-channel downstream occupancy, 1 = occupied |
| vc_awake | input | NUM_VC | Per-channel power state, 1 = awake |
| grant_valid | output | 1 | Grant pulse |
| grant_vc | output | VCW | Granted channel number |
| wake_req | output | NUM_VC | One-hot wake request for the channel being waited on |

## Verification
The bound checker holds on every cycle that a grant only names a channel that was free and awake one cycle earlier. It also holds that a grant never falls below the accepted starting channel, that grants are single pulses, and that wake requests are one-hot, point at a sleeping channel, and are silent during a grant. Only the bench scenarios can show that the chosen channel is the lowest legal one, which needs a full sweep of start channel, injection and occupancy on 4-channel and 3-channel instances. The same holds for the clamping of out-of-range channel numbers, the wait-then-grant sequences after release or wakeup, and the fact that a second strobe during a pending header changes nothing.

// File: rtl/vc_sel_pkg.sv
package vc_sel_pkg;

    localparam int unsigned VC_LIMIT = 4;

    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_PEND = 1'b1
    } sel_state_e;

    function automatic int unsigned vc_index_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vc_start_clamp.sv
module vc_start_clamp #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned VCW    = 2
) (
    input  logic [VCW-1:0] hdr_vc,
    input  logic           inject,
    output logic [VCW-1:0] start_vc
);

    localparam logic [VCW-1:0] TOP_VC = VCW'(NUM_VC - 1);

    logic [VCW-1:0] ranged_vc;

    generate
        if (NUM_VC == (1 << VCW)) begin : g_full_range
            assign ranged_vc = hdr_vc;
        end else begin : g_clamped
            assign ranged_vc = (hdr_vc > TOP_VC) ? TOP_VC : hdr_vc;
        end
    endgenerate

    // injected headers always enter on the lowest layer
    assign start_vc = inject ? '0 : ranged_vc;

endmodule

// File: rtl/vc_upward_pick.sv
module vc_upward_pick #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned VCW    = 2
) (
    input  logic [VCW-1:0]    start_vc,
    input  logic [NUM_VC-1:0] vc_busy,
    output logic              found,
    output logic [VCW-1:0]    pick_vc
);

    // lowest free channel at or above the start; scan downward so the
    // last hit wins
    always_comb begin
        found   = 1'b0;
        pick_vc = '0;
        for (int i = NUM_VC - 1; i >= 0; i--) begin
            if ((i >= int'(start_vc)) && !vc_busy[i]) begin
                found   = 1'b1;
                pick_vc = VCW'(i);
            end
        end
    end

endmodule

// File: rtl/vc_selector.sv
module vc_selector
    import vc_sel_pkg::*;
#(
    parameter int unsigned NUM_VC = 4,
    localparam int unsigned VCW   = vc_index_width(NUM_VC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [VCW-1:0]    hdr_vc,
    input  logic              inject,
    input  logic [NUM_VC-1:0] vc_busy,
    input  logic [NUM_VC-1:0] vc_awake,
    output logic              grant_valid,
    output logic [VCW-1:0]    grant_vc,
    output logic [NUM_VC-1:0] wake_req
);

    typedef struct packed {
        sel_state_e        st;
        logic [VCW-1:0]    cur;
        logic              gnt;
        logic [VCW-1:0]    gvc;
        logic [NUM_VC-1:0] wake;
    } sel_regs_t;

    sel_regs_t r_q, r_d;

    logic [VCW-1:0] start_in;
    logic           cand_found;
    logic [VCW-1:0] cand_vc;

    vc_start_clamp #(.NUM_VC(NUM_VC), .VCW(VCW)) u_clamp (
        .hdr_vc   (hdr_vc),
        .inject   (inject),
        .start_vc (start_in)
    );

    vc_upward_pick #(.NUM_VC(NUM_VC), .VCW(VCW)) u_pick (
        .start_vc (r_q.cur),
        .vc_busy  (vc_busy),
        .found    (cand_found),
        .pick_vc  (cand_vc)
    );

    always_comb begin
        r_d      = r_q;
        r_d.gnt  = 1'b0;
        r_d.wake = '0;
        case (r_q.st)
            SEL_IDLE: begin
                if (hdr_valid) begin
                    r_d.st  = SEL_PEND;
                    r_d.cur = start_in;
                end
            end
            SEL_PEND: begin
                if (cand_found) begin
                    if (vc_awake[cand_vc]) begin
                        r_d.gnt = 1'b1;
                        r_d.gvc = cand_vc;
                        r_d.st  = SEL_IDLE;
                    end else begin
                        r_d.wake[cand_vc] = 1'b1;
                    end
                end
            end
            default: r_d.st = SEL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: SEL_IDLE, cur: '0, gnt: 1'b0, gvc: '0, wake: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign grant_valid = r_q.gnt;
    assign grant_vc    = r_q.gvc;
    assign wake_req    = r_q.wake;

endmodule

// File: rtl/vc_selector_chk.sv
module vc_selector_chk #(
    parameter int unsigned NUM_VC = 4,
    parameter int unsigned VCW    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [VCW-1:0]    hdr_vc,
    input logic              inject,
    input logic [NUM_VC-1:0] vc_busy,
    input logic [NUM_VC-1:0] vc_awake,
    input logic              grant_valid,
    input logic [VCW-1:0]    grant_vc,
    input logic [NUM_VC-1:0] wake_req
);

    logic [NUM_VC-1:0] busy_p, awake_p;
    logic              pend_c;
    logic [VCW-1:0]    floor_c;
    logic [VCW-1:0]    floor_now;

    always_comb begin
        if (inject) floor_now = '0;
        else if (int'(hdr_vc) > int'(NUM_VC) - 1) floor_now = VCW'(NUM_VC - 1);
        else floor_now = hdr_vc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_c  <= 1'b0;
            floor_c <= '0;
            busy_p  <= '1;
            awake_p <= '0;
        end else begin
            busy_p  <= vc_busy;
            awake_p <= vc_awake;
            if (hdr_valid && (!pend_c || grant_valid)) begin
                pend_c  <= 1'b1;
                floor_c <= floor_now;
            end else if (grant_valid) begin
                pend_c <= 1'b0;
            end
        end
    end

    assert_grant_target_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (!busy_p[grant_vc] && awake_p[grant_vc]));

    assert_grant_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (pend_c && (grant_vc >= floor_c)));

    assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    assert_wake_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_req));

    assert_grant_quiet_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (wake_req == '0));

    assert_wake_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req != '0) |-> ((wake_req & awake_p) == '0));

endmodule

bind vc_selector vc_selector_chk #(.NUM_VC(NUM_VC), .VCW(VCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_vc      (hdr_vc),
    .inject      (inject),
    .vc_busy     (vc_busy),
    .vc_awake    (vc_awake),
    .grant_valid (grant_valid),
    .grant_vc    (grant_vc),
    .wake_req    (wake_req)
);

// File: tb/tb_vc_selector.sv
`timescale 1ns/1ps
module tb_vc_selector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hdr_valid = 1'b0;
    logic [1:0] hdr_vc = '0;
    logic       inject = 1'b0;
    logic [3:0] busy = '0;
    logic [3:0] awake = '1;

    logic       gv4, gv3;
    logic [1:0] gvc4, gvc3;
    logic [3:0] wk4;
    logic [2:0] wk3;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vc_selector #(.NUM_VC(4)) dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_vc(hdr_vc),
        .inject(inject), .vc_busy(busy), .vc_awake(awake),
        .grant_valid(gv4), .grant_vc(gvc4), .wake_req(wk4)
    );

    vc_selector #(.NUM_VC(3)) dut3 (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_vc(hdr_vc),
        .inject(inject), .vc_busy(busy[2:0]), .vc_awake(awake[2:0]),
        .grant_valid(gv3), .grant_vc(gvc3), .wake_req(wk3)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int start_of(input int cur, input bit inj, input int n);
        if (inj) return 0;
        return (cur > n - 1) ? n - 1 : cur;
    endfunction

    function automatic int exp_pick(input int cur, input bit inj, input int bz, input int n);
        int s = start_of(cur, inj, n);
        for (int i = s; i < n; i++) if (!bz[i]) return i;
        return -1;
    endfunction

    function automatic string tag_for(input int cur, input bit inj, input int e, input int n);
        if (e < 0) return "R7";
        if (inj) return "R3";
        if (cur > n - 1) return "R4";
        if (e == cur) return "R5";
        return "R6";
    endfunction

    task automatic strobe(input int cur, input bit inj);
        @(negedge clk);
        hdr_vc = 2'(cur); inject = inj; hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic run_case(input int cur, input bit inj, input int bz);
        int e4, e3;
        @(negedge clk);
        busy = 4'(bz); awake = '1;
        strobe(cur, inj);
        @(negedge clk);
        e4 = exp_pick(cur, inj, bz, 4);
        e3 = exp_pick(cur, inj, bz, 3);
        if (e4 >= 0) check(gv4 && gvc4 == 2'(e4), tag_for(cur, inj, e4, 4), gv4 ? int'(gvc4) : -1, e4);
        else         check(!gv4, "R7", int'(gv4), 0);
        if (e3 >= 0) check(gv3 && gvc3 == 2'(e3), tag_for(cur, inj, e3, 3), gv3 ? int'(gvc3) : -1, e3);
        else         check(!gv3, "R7", int'(gv3), 0);
        if (e4 < 0 || e3 < 0) begin
            busy = '0;
            @(negedge clk);
            if (e4 < 0) check(gv4 && int'(gvc4) == start_of(cur, inj, 4), "R7",
                              gv4 ? int'(gvc4) : -1, start_of(cur, inj, 4));
            if (e3 < 0) check(gv3 && int'(gvc3) == start_of(cur, inj, 3), "R7",
                              gv3 ? int'(gvc3) : -1, start_of(cur, inj, 3));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(!gv4 && wk4 == 4'b0, "R1", int'({gv4, wk4}), 0);
        check(!gv3 && wk3 == 3'b0, "R1", int'({gv3, wk3}), 0);

        // sweep: start channel x injection x occupancy (R3..R7)
        for (int c = 0; c < 4; c++)
            for (int j = 0; j < 2; j++)
                for (int b = 0; b < 16; b++)
                    run_case(c, bit'(j), b);

        // R8: chosen channel asleep, then wakes
        @(negedge clk);
        busy = 4'b0000; awake = 4'b1101;
        strobe(1, 1'b0);
        @(negedge clk);
        check(!gv4, "R8", int'(gv4), 0);
        check(wk4 == 4'b0010, "R8", int'(wk4), 2);
        @(negedge clk);
        check(!gv4 && wk4 == 4'b0010, "R8", int'({gv4, wk4}), 2);
        awake = 4'b1111;
        @(negedge clk);
        check(gv4 && gvc4 == 2'd1, "R8", gv4 ? int'(gvc4) : -1, 1);
        check(wk4 == 4'b0, "R10", int'(wk4), 0);
        repeat (2) @(negedge clk);

        // R8: upward move onto a sleeping channel
        busy = 4'b0011; awake = 4'b1011;
        strobe(0, 1'b0);
        @(negedge clk);
        check(!gv4 && wk4 == 4'b0100, "R8", int'({gv4, wk4}), 4);
        awake = 4'b1111;
        @(negedge clk);
        check(gv4 && gvc4 == 2'd2, "R8", gv4 ? int'(gvc4) : -1, 2);
        repeat (2) @(negedge clk);

        // R9: second strobe while pending is ignored
        busy = 4'b1111; awake = 4'b1111;
        strobe(2, 1'b0);
        strobe(0, 1'b0);
        busy = 4'b1110;
        @(negedge clk);
        @(negedge clk);
        check(!gv4, "R9", int'(gv4), 0);
        busy = 4'b0000;
        @(negedge clk);
        check(gv4 && gvc4 == 2'd2, "R9", gv4 ? int'(gvc4) : -1, 2);
        @(negedge clk);
        // R2: grant is a single pulse
        check(!gv4, "R2", int'(gv4), 0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule